// File: doc/BRIEF.md
# Pipelined Baugh-Wooley array multiplier

This block multiplies two operands of a parameterized width (4 bits by default) and returns a product twice that width. A mode input chooses how the operands are read. In signed mode they are two's-complement numbers. In unsigned mode they are plain binary. The mode is sampled with each operand pair, so consecutive pairs can use different modes.

In signed mode, each partial-product bit that pairs exactly one sign bit with a non-sign bit is inverted. Two constant ones are then added to the sum. After this step every row has positive weight, so no row needs sign extension. All rows therefore pass through the same carry-save array of one-bit full adders. Each full adder is built only from three-input majority gates and inverters.

A register stage follows every carry-save row. A final ripple stage, built from the same adders, resolves the sum and carry vectors. The block accepts one operand pair per clock. A valid strobe travels alongside the data.

Top module: `bw_mult`

## Requirements
- R1: When `signed_i` is 1, `prod_o` is the two's-complement product of `a_i` and `b_i`, given as 2·W bits.
- R2: When `signed_i` is 0, `prod_o` is the unsigned product of `a_i` and `b_i`, given as 2·W bits.
- R3: A pair sampled with `valid_i`=1 on a rising edge appears on `prod_o`, with `valid_o`=1, after W rising edges, counting that edge as the first. One edge earlier, `valid_o` is still 0.
- R4: A new pair is accepted on every clock, with `signed_i` free to change from one pair to the next. Results leave in input order, one result for each accepted pair.
- R5: A cycle with `valid_i`=0 produces a cycle with `valid_o`=0 W edges later, whatever `a_i`, `b_i` and `signed_i` are.
- R6: While `rst_ni` is low, `valid_o` and `prod_o` are 0. Pairs that were in flight when reset was asserted never appear.
- R7: In signed mode, the most negative operand squared, −2^(W−1)·−2^(W−1), gives +2^(2W−2). More generally, when both operands are nonzero, the top product bit equals the XOR of the two operand sign bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair present |
| signed_i | input | 1 | 1: two's-complement operands; 0: unsigned |
| a_i | input | W | Multiplicand |
| b_i | input | W | Multiplier |
| valid_o | output | 1 | Product present |
| prod_o | output | 2·W | Product |

## Verification
Hand-picked vectors are run one at a time. They include the most negative operand squared, −1·−1, maximum positive by most negative, all-ones in unsigned mode, and zero operands. These vectors separate a wrong complement pattern or a misplaced correction constant from plain array errors. Each vector also checks the latency edge.

The bench then streams every operand pair in both modes back to back, flipping the mode on every cycle and inserting occasional idle cycles. This catches a mode bit that is out of step with the data. It also catches lost or duplicated results.

A reset asserted in the middle of the stream, followed by idle cycles with changing operands, shows that state in flight is flushed. It also shows that inputs arriving without `valid_i` produce nothing.

// File: rtl/bw_pkg.sv
package bw_pkg;
  // three-input majority: the only logic primitive besides inversion
  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/bw_maj_fa.sv
module bw_maj_fa
  import bw_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  logic inner;
  assign co_o  = maj3(x_i, y_i, c_i);
  assign inner = maj3(x_i, y_i, ~c_i);
  assign s_o   = maj3(~co_o, c_i, inner);
endmodule

// File: rtl/bw_pp_row.sv
module bw_pp_row
  import bw_pkg::*;
#(
  parameter int W   = 4,
  parameter int ROW = 0,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]  a_i,
  input  logic          bj_i,
  input  logic          sgn_i,
  output logic [PW-1:0] row_o
);
  logic [W-1:0] term;
  for (genvar i = 0; i < W; i++) begin : g_bit
    // AND as majority with a grounded input; invert mixed sign-bit terms
    localparam bit MIXED = (i == W - 1) != (ROW == W - 1);
    if (MIXED) begin : g_mix
      assign term[i] = maj3(a_i[i], bj_i, 1'b0) ^ sgn_i;
    end else begin : g_plain
      assign term[i] = maj3(a_i[i], bj_i, 1'b0);
    end
  end
  assign row_o = PW'({{W{1'b0}}, term} << ROW);
endmodule

// File: rtl/bw_csa_row.sv
module bw_csa_row #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] x_i,
  input  logic [PW-1:0] y_i,
  input  logic [PW-1:0] z_i,
  output logic [PW-1:0] s_o,
  output logic [PW-1:0] c_o
);
  logic [PW-1:0] co;
  for (genvar i = 0; i < PW; i++) begin : g_fa
    bw_maj_fa u_fa (.x_i(x_i[i]), .y_i(y_i[i]), .c_i(z_i[i]), .s_o(s_o[i]), .co_o(co[i]));
  end
  // carries move up one weight; the top carry falls outside the product
  assign c_o = {co[PW-2:0], 1'b0};
endmodule

// File: rtl/bw_ripple.sv
module bw_ripple #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] x_i,
  input  logic [PW-1:0] y_i,
  output logic [PW-1:0] s_o
);
  logic [PW:0] cy;
  assign cy[0] = 1'b0;
  for (genvar i = 0; i < PW; i++) begin : g_fa
    bw_maj_fa u_fa (.x_i(x_i[i]), .y_i(y_i[i]), .c_i(cy[i]), .s_o(s_o[i]), .co_o(cy[i+1]));
  end
endmodule

// File: rtl/bw_mult.sv
module bw_mult #(
  parameter int W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic           signed_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           valid_o,
  output logic [2*W-1:0] prod_o
);
  localparam int PW  = 2 * W;
  localparam int NST = W - 1;
  localparam logic [PW-1:0] CORR = PW'((1 << W) | (1 << (PW - 1)));

  logic [W-1:0]  a_q [NST];
  logic [W-1:0]  b_q [NST];
  logic          sg_q[NST];
  logic          v_q [NST];
  logic [PW-1:0] s_q [NST];
  logic [PW-1:0] c_q [NST];

  for (genvar k = 0; k < NST; k++) begin : g_st
    logic [PW-1:0] x, y, z, s_d, c_d;
    logic [W-1:0]  a_src, b_src;
    logic          sg_src, v_src;

    if (k == 0) begin : g_first
      assign a_src  = a_i;
      assign b_src  = b_i;
      assign sg_src = signed_i;
      assign v_src  = valid_i;
      bw_pp_row #(.W(W), .ROW(0)) u_pp0 (.a_i(a_i), .bj_i(b_i[0]), .sgn_i(signed_i), .row_o(x));
      bw_pp_row #(.W(W), .ROW(1)) u_pp1 (.a_i(a_i), .bj_i(b_i[1]), .sgn_i(signed_i), .row_o(y));
      assign z = signed_i ? CORR : '0;
    end else begin : g_next
      assign a_src  = a_q[k-1];
      assign b_src  = b_q[k-1];
      assign sg_src = sg_q[k-1];
      assign v_src  = v_q[k-1];
      assign x      = s_q[k-1];
      assign y      = c_q[k-1];
      bw_pp_row #(.W(W), .ROW(k + 1)) u_pp (.a_i(a_q[k-1]), .bj_i(b_q[k-1][k+1]),
                                           .sgn_i(sg_q[k-1]), .row_o(z));
    end

    bw_csa_row #(.PW(PW)) u_csa (.x_i(x), .y_i(y), .z_i(z), .s_o(s_d), .c_o(c_d));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q[k]  <= '0;
        b_q[k]  <= '0;
        sg_q[k] <= 1'b0;
        v_q[k]  <= 1'b0;
        s_q[k]  <= '0;
        c_q[k]  <= '0;
      end else begin
        a_q[k]  <= a_src;
        b_q[k]  <= b_src;
        sg_q[k] <= sg_src;
        v_q[k]  <= v_src;
        s_q[k]  <= s_d;
        c_q[k]  <= c_d;
      end
    end
  end

  logic [PW-1:0] sum_d;
  bw_ripple #(.PW(PW)) u_cpa (.x_i(s_q[NST-1]), .y_i(c_q[NST-1]), .s_o(sum_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      prod_o  <= '0;
    end else begin
      valid_o <= v_q[NST-1];
      prod_o  <= sum_d;
    end
  end
endmodule

// File: rtl/bw_mult_chk.sv
module bw_mult_chk #(
  parameter int W = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic           signed_i,
  input logic [W-1:0]   a_i,
  input logic [W-1:0]   b_i,
  input logic           valid_o,
  input logic [2*W-1:0] prod_o
);
  localparam int PW  = 2 * W;
  localparam int LAT = W;

  logic         v_d [LAT];
  logic         s_d [LAT];
  logic [W-1:0] a_d [LAT];
  logic [W-1:0] b_d [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < LAT; k++) begin
        v_d[k] <= 1'b0; s_d[k] <= 1'b0; a_d[k] <= '0; b_d[k] <= '0;
      end
    end else begin
      v_d[0] <= valid_i; s_d[0] <= signed_i; a_d[0] <= a_i; b_d[0] <= b_i;
      for (int k = 1; k < LAT; k++) begin
        v_d[k] <= v_d[k-1]; s_d[k] <= s_d[k-1]; a_d[k] <= a_d[k-1]; b_d[k] <= b_d[k-1];
      end
    end
  end

  logic [W-1:0]  ea, eb;
  logic          es;
  logic [PW-1:0] ref_s, ref_u;
  assign ea = a_d[LAT-1];
  assign eb = b_d[LAT-1];
  assign es = s_d[LAT-1];
  always_comb begin
    ref_s = PW'({{W{ea[W-1]}}, ea} * {{W{eb[W-1]}}, eb});
    ref_u = PW'({{W{1'b0}}, ea} * {{W{1'b0}}, eb});
  end

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_d[LAT-1]);
  assert_signed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && es) |-> prod_o == ref_s);
  assert_unsigned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !es) |-> prod_o == ref_u);
  assert_sign_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && es && ea != '0 && eb != '0) |-> prod_o[PW-1] == (ea[W-1] ^ eb[W-1]));
  assert_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_d[LAT-1] |-> !valid_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R6: assert (!valid_o && prod_o == '0);
    end
  end
endmodule

bind bw_mult bw_mult_chk #(.W(W)) u_chk (.*);

// File: tb/bw_mult_tb.sv
`timescale 1ns/1ps
module bw_mult_tb;
  localparam int W  = 4;
  localparam int PW = 2 * W;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic          signed_i = 1'b0;
  logic [W-1:0]  a_i = '0;
  logic [W-1:0]  b_i = '0;
  logic          valid_o;
  logic [PW-1:0] prod_o;

  always #5 clk_i = ~clk_i;

  bw_mult #(.W(W)) u_dut (.*);

  int n_run  = 0;
  int n_fail = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ref_mul(input logic s, input logic [W-1:0] a, input logic [W-1:0] b);
    if (s) return PW'($signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b}));
    return PW'({{W{1'b0}}, a} * {{W{1'b0}}, b});
  endfunction

  // {signed, a, b, expected product}
  localparam logic [16:0] VEC [9] = '{
    {1'b1, 4'h8, 4'h8, 8'h40},
    {1'b1, 4'h7, 4'h7, 8'h31},
    {1'b1, 4'h8, 4'h7, 8'hC8},
    {1'b1, 4'hF, 4'hF, 8'h01},
    {1'b1, 4'hF, 4'h1, 8'hFF},
    {1'b0, 4'hF, 4'hF, 8'hE1},
    {1'b0, 4'h8, 4'h8, 8'h40},
    {1'b0, 4'h0, 4'hB, 8'h00},
    {1'b1, 4'h0, 4'h8, 8'h00}
  };

  logic [PW-1:0] exp_q [1024];
  logic          mod_q [1024];
  int wr = 0;
  int rd = 0;

  task automatic sample_out();
    if (valid_o) begin
      if (rd < wr) begin
        check(mod_q[rd] ? "R1 R4 stream signed" : "R2 R4 stream unsigned", 32'(prod_o), 32'(exp_q[rd]));
        rd++;
      end else begin
        check("R4 extra result", 32'(valid_o), 32'd0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R6 reset valid", 32'(valid_o), 32'd0);
    check("R6 reset prod", 32'(prod_o), 32'd0);
    rst_ni = 1'b1;

    // table walk, one pair at a time, latency edge checked
    for (int v = 0; v < 9; v++) begin
      @(negedge clk_i);
      signed_i = VEC[v][16];
      a_i      = VEC[v][15:12];
      b_i      = VEC[v][11:8];
      valid_i  = 1'b1;
      @(negedge clk_i);
      valid_i  = 1'b0;
      repeat (W - 2) @(posedge clk_i);
      @(negedge clk_i);
      check("R3 not early", 32'(valid_o), 32'd0);
      @(negedge clk_i);
      check("R3 valid at latency", 32'(valid_o), 32'd1);
      if (VEC[v][16] && VEC[v][15:12] == 4'h8 && VEC[v][11:8] == 4'h8)
        check("R7 most negative squared", 32'(prod_o), 32'(VEC[v][7:0]));
      else if (VEC[v][16])
        check("R1 table", 32'(prod_o), 32'(VEC[v][7:0]));
      else
        check("R2 table", 32'(prod_o), 32'(VEC[v][7:0]));
    end

    // exhaustive stream, mode toggling every pair, sparse bubbles
    begin
      int idx = 0;
      int cyc = 0;
      while (idx < 512) begin
        @(negedge clk_i);
        sample_out();
        if (cyc % 37 == 36) begin
          valid_i = 1'b0;
        end else begin
          logic [8:0] ix;
          ix       = 9'(idx);
          signed_i = ix[0];
          a_i      = ix[4:1];
          b_i      = ix[8:5];
          valid_i  = 1'b1;
          exp_q[wr] = ref_mul(ix[0], ix[4:1], ix[8:5]);
          mod_q[wr] = ix[0];
          wr++;
          idx++;
        end
        cyc++;
      end
      @(negedge clk_i);
      sample_out();
      valid_i = 1'b0;
      repeat (W + 2) begin
        @(negedge clk_i);
        sample_out();
      end
      check("R4 all results delivered", 32'(rd), 32'(wr));
    end

    // reset with pairs in flight
    @(negedge clk_i);
    signed_i = 1'b1; a_i = 4'h5; b_i = 4'h3; valid_i = 1'b1;
    @(negedge clk_i);
    a_i = 4'h6;
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    @(negedge clk_i);
    check("R6 flush valid", 32'(valid_o), 32'd0);
    check("R6 flush prod", 32'(prod_o), 32'd0);
    rst_ni = 1'b1;
    for (int k = 0; k < W + 2; k++) begin
      @(negedge clk_i);
      check("R6 nothing stale", 32'(valid_o), 32'd0);
    end

    // operands without strobe produce nothing
    for (int k = 0; k < W + 3; k++) begin
      @(negedge clk_i);
      a_i = 4'(k * 3 + 1); b_i = 4'(k + 9); signed_i = k[0];
      check("R5 no valid in, no valid out", 32'(valid_o), 32'd0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule